// File: doc/BRIEF.md
# Divider and programmable interval timer

This block combines a free-running machine-cycle divider with an 8-bit programmable counter. Each clock cycle is one machine cycle. The divider advances on every cycle. The counter advances whenever a chosen divider bit, gated by an enable flag, falls from 1 to 0. When the counter passes its top value it restarts from a software-set modulo value and raises a one-cycle interrupt request.

The CPU reaches four byte registers through a small register port: an address, a write strobe, write data and combinational read data. The divider view is the upper byte of the internal divider, the counter and the modulo value are plain bytes, and the control register holds the enable flag and the tap selector.

A counter step comes from any high-to-low change of the gated tap. A CPU write that clears the divider, or that changes the control register, can cause that change, so such a write can add one extra count.

Top module: `interval_timer`

## Requirements
- R1: A 14-bit divider increments on every clock cycle and wraps from 0x3FFF to 0. A read at address 0 returns divider bits 13:6.
- R2: In the control register (address 3), bit 2 enables counting and bits 1:0 pick the tap: 0 selects divider bit 7, 1 selects bit 1, 2 selects bit 3 and 3 selects bit 5. The counter (address 1) rises by one on each cycle where enable AND the selected tap goes from 1 to 0, and it holds its value in every other cycle.
- R3: A step taken while the counter is 0xFF loads the modulo value held before that clock edge. One cycle later `irq_timer` is high for exactly one cycle.
- R4: A write to address 0, whatever the data, clears the whole divider. If the gated tap was 1 just before the clear, the counter gains one count.
- R5: A control write stores only data bits 2:0, and a read of address 3 returns 1 in bits 7:3. If the write turns the gated tap from 1 to 0, the counter gains one count. A write that leaves the gated tap at 1, or that raises it from 0, adds no count.
- R6: A CPU write to the counter in the same cycle as a step stores the written byte. The step is dropped, and no interrupt is raised even if the counter was 0xFF.
- R7: A synchronous active-low reset clears the divider, counter, modulo and control registers and the interrupt output.
- R8: The modulo register (address 2) reads back the last byte written. A modulo write on the same edge as an overflow takes effect only for later reloads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one machine cycle per period |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 divider, 1 counter, 2 modulo, 3 control |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the selected register |
| irq_timer | output | 1 | One-cycle interrupt request on counter overflow |

## Verification
The bench builds the block with its default parameters: a 14-bit divider, taps 7, 1, 3 and 5, and 8-bit registers. At these values a full divider wrap takes 16384 cycles, so the bench sweeps the whole divider range and runs every tap selection over nearly a full divider period. The fastest tap overflows the counter every 1024 cycles, so repeated reloads and interrupt counts are reached in a short run. The spurious-count cases are reached by placing the divider at chosen values with a divider clear followed by a known wait, so each write lands on a known tap level.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Package: shared register selects and control-field layout for the interval timer.
// Assumes a two-bit register address on the CPU register port.
package tmr_pkg;

    typedef enum logic [1:0] {
        SEL_DIV = 2'd0,
        SEL_CNT = 2'd1,
        SEL_MOD = 2'd2,
        SEL_CTL = 2'd3
    } tmr_sel_e;

    localparam int CTL_W      = 3;
    localparam int CTL_EN_BIT = 2;
    localparam int NUM_TAPS   = 4;

endpackage

// File: rtl/tmr_divider.sv
`timescale 1ns/1ps
// Module: tmr_divider
// Free-running machine-cycle divider. It clears on request, and it also
// exposes the value it will hold after the coming edge, so that the edge
// detector can compare the present and next tap levels.
// Assumes one clock edge per machine cycle.
module tmr_divider #(
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [DIV_W-1:0] div_q,
    output logic [DIV_W-1:0] div_nxt
);

    // Next divider value: cleared by a CPU write, otherwise one step on.
    always_comb begin
        div_nxt = clr ? '0 : div_q + DIV_W'(1);
    end

    // Divider register.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_nxt;
    end

    // R1: without a clear the divider advances by exactly one, with wrap.
    assert_div_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> div_q == $past(div_q) + DIV_W'(1));

endmodule

// File: rtl/tmr_edge.sv
`timescale 1ns/1ps
// Module: tmr_edge
// Gated-tap falling-edge detector. It compares the gated tap now with the
// gated tap after the coming edge, with control and divider updates taken
// into account, and requests one counter step on a 1-to-0 change.
// Assumes tap levels are supplied for every selector value.
module tmr_edge
    import tmr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAPS-1:0] tap_cur,
    input  logic [NUM_TAPS-1:0] tap_nxt,
    input  logic [CTL_W-1:0]    ctl_cur,
    input  logic [CTL_W-1:0]    ctl_nxt,
    output logic                step
);

    logic gated_cur;
    logic gated_nxt;

    // Gated tap before and after the coming edge, and the falling-edge step.
    always_comb begin
        gated_cur = ctl_cur[CTL_EN_BIT] & tap_cur[ctl_cur[1:0]];
        gated_nxt = ctl_nxt[CTL_EN_BIT] & tap_nxt[ctl_nxt[1:0]];
        step      = gated_cur & ~gated_nxt;
    end

    // R2: after a fall the gated tap is low, so two steps never follow each other.
    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);

endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
// Module: tmr_counter
// Programmable counter with modulo reload and registered overflow request.
// A CPU write to the counter wins over a step in the same cycle.
// Assumes at most one step per cycle.
module tmr_counter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              wr_cnt,
    input  logic              wr_mod,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] mod_q,
    output logic              irq
);

    logic at_top;

    // Counter sits at its largest value.
    always_comb begin
        at_top = (cnt_q == {DATA_W{1'b1}});
    end

    // Counter: CPU write first, then step with reload on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_cnt) cnt_q <= wdata;
        else if (step)   cnt_q <= at_top ? mod_q : cnt_q + DATA_W'(1);
    end

    // Modulo register.
    always_ff @(posedge clk) begin
        if (!rst_n)      mod_q <= '0;
        else if (wr_mod) mod_q <= wdata;
    end

    // Overflow request, one cycle after the reloading edge.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= step & at_top & ~wr_cnt;
    end

    // R3: the request lasts a single cycle.
    assert_irq_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R3 / R8: when the request shows, the counter holds the previous modulo value.
    assert_reload_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cnt_q == $past(mod_q));

    // R6: a CPU counter write always lands, whatever the step does.
    assert_cpu_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> cnt_q == $past(wdata));

    // R2: no step and no write leaves the counter unchanged.
    assert_hold_without_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_cnt) |=> $stable(cnt_q));

endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
// Module: interval_timer
// Divider plus programmable interval counter behind a four-register CPU port.
// Decodes writes, holds the control register, picks the divider taps and
// multiplexes read data. Assumes one clock per machine cycle and
// combinational reads.
module interval_timer
    import tmr_pkg::*;
#(
    parameter int DIV_W  = 14,
    parameter int DATA_W = 8,
    parameter int TAP_0  = 7,
    parameter int TAP_1  = 1,
    parameter int TAP_2  = 3,
    parameter int TAP_3  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_timer
);

    localparam int PAD_W = DATA_W - CTL_W;

    logic                wr_div;
    logic                wr_cnt;
    logic                wr_mod;
    logic                wr_ctl;
    logic [CTL_W-1:0]    ctl_q;
    logic [CTL_W-1:0]    ctl_nxt;
    logic [DIV_W-1:0]    div_q;
    logic [DIV_W-1:0]    div_nxt;
    logic [NUM_TAPS-1:0] tap_cur;
    logic [NUM_TAPS-1:0] tap_nxt;
    logic                step;
    logic [DATA_W-1:0]   cnt_q;
    logic [DATA_W-1:0]   mod_q;
    logic                unused_div_bits;

    // Write decode per register.
    always_comb begin
        wr_div = bus_we && (bus_addr == SEL_DIV);
        wr_cnt = bus_we && (bus_addr == SEL_CNT);
        wr_mod = bus_we && (bus_addr == SEL_MOD);
        wr_ctl = bus_we && (bus_addr == SEL_CTL);
    end

    // Control value after the coming edge.
    always_comb begin
        ctl_nxt = wr_ctl ? bus_wdata[CTL_W-1:0] : ctl_q;
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_nxt;
    end

    tmr_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wr_div),
        .div_q   (div_q),
        .div_nxt (div_nxt)
    );

    // Tap extraction, one divider bit per selector value.
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int TP = (g == 0) ? TAP_0 : (g == 1) ? TAP_1 :
                            (g == 2) ? TAP_2 : TAP_3;
        assign tap_cur[g] = div_q[TP];
        assign tap_nxt[g] = div_nxt[TP];
    end

    // Bits that feed no tap and no read view are folded away here.
    assign unused_div_bits = ^{div_q, div_nxt};

    tmr_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap_cur (tap_cur),
        .tap_nxt (tap_nxt),
        .ctl_cur (ctl_q),
        .ctl_nxt (ctl_nxt),
        .step    (step)
    );

    tmr_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .wr_cnt (wr_cnt),
        .wr_mod (wr_mod),
        .wdata  (bus_wdata),
        .cnt_q  (cnt_q),
        .mod_q  (mod_q),
        .irq    (irq_timer)
    );

    // Read multiplexer.
    always_comb begin
        unique case (bus_addr)
            SEL_DIV: bus_rdata = div_q[DIV_W-1 -: DATA_W];
            SEL_CNT: bus_rdata = cnt_q;
            SEL_MOD: bus_rdata = mod_q;
            default: bus_rdata = {{PAD_W{1'b1}}, ctl_q};
        endcase
    end

    // R5: a control write keeps exactly the low field of the written byte.
    assert_ctl_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> ctl_q == $past(bus_wdata[CTL_W-1:0]));

    // R4: a divider write leaves the divider view at zero on the next cycle.
    assert_div_clear_view_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_div |=> (bus_addr != SEL_DIV) || (bus_rdata == '0));

endmodule

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
// Bench for interval_timer: directed sweeps with arithmetic expected values.
module interval_timer_tb_top;
    import tmr_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_timer;

    int n_chk = 0;
    int n_err = 0;
    int irq_seen = 0;
    bit irq_prev = 1'b0;
    bit done = 1'b0;
    int tapb [4] = '{7, 1, 3, 5};

    interval_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_timer (irq_timer)
    );

    always #10 clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Interrupt monitor: counts pulses and flags any pulse longer than one cycle (R3).
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_timer) begin
                irq_seen++;
                n_chk++;
                if (irq_prev) begin
                    n_err++;
                    $display("FAIL R3 irq width: actual 2+ cycles expected 1");
                end
            end
            irq_prev = irq_timer;
        end else begin
            irq_prev = 1'b0;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    // Leaves the divider at value k with the counter preset to init and tap sel enabled.
    task automatic setup(int sel, int k, int init);
        wr(SEL_CTL, 8'h00);
        wr(SEL_CNT, 8'(init));
        wr(SEL_DIV, 8'h00);
        wr(SEL_CTL, 8'(4 | sel));
        if (k > 1) step(k - 1);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int v;
        int base;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R7: values just after reset.
        rd(SEL_DIV, v); check("R7", "div after reset", v, 0);
        rd(SEL_CNT, v); check("R7", "cnt after reset", v, 0);
        rd(SEL_MOD, v); check("R7", "mod after reset", v, 0);
        rd(SEL_CTL, v); check("R7", "ctl after reset", v, 8'hF8);
        check("R7", "irq after reset", int'(irq_timer), 0);

        // R1: full divider sweep including wrap.
        wr(SEL_CTL, 8'h00);
        wr(SEL_DIV, 8'h00);
        for (int k = 0; k <= 16384 + 256; k++) begin
            if ((k % 61) == 0 || k == 16383 || k == 16384) begin
                rd(SEL_DIV, v);
                check("R1", "div view", v, (k % 16384) >> 6);
            end
            step(1);
        end

        // R4: divider write clears the high bits too.
        step(200);
        wr(SEL_DIV, 8'h5A);
        rd(SEL_DIV, v); check("R4", "div cleared", v, 0);

        // R2: count rate for every tap selection, modulo 0.
        wr(SEL_MOD, 8'h00);
        for (int sel = 0; sel < 4; sel++) begin
            setup(sel, 1, 0);
            base = irq_seen;
            for (int w = 0; w < 16000; w++) begin
                if ((w % 97) == 0) begin
                    int n;
                    n = (1 + w) >> (tapb[sel] + 1);
                    rd(SEL_CNT, v); check("R2", "count rate", v, n & 255);
                    check("R3", "irq count", irq_seen - base, n >> 8);
                end
                step(1);
            end
        end

        // R3 / R8: reload from a nonzero modulo value.
        wr(SEL_MOD, 8'hF0);
        rd(SEL_MOD, v); check("R8", "mod readback", v, 8'hF0);
        setup(1, 1, 0);
        base = irq_seen;
        for (int w = 0; w < 3000; w++) begin
            if ((w % 53) == 0) begin
                int n;
                n = (1 + w) >> 2;
                rd(SEL_CNT, v);
                check("R3", "reload count", v, (n < 256) ? n : 8'hF0 + ((n - 256) % 16));
                check("R3", "reload irq", irq_seen - base, (n < 256) ? 0 : 1 + (n - 256) / 16);
            end
            step(1);
        end

        // R4: divider write with tap low adds nothing, with tap high adds one.
        setup(1, 1, 0);
        wr(SEL_DIV, 8'h00);
        rd(SEL_CNT, v); check("R4", "clear with tap low", v, 0);
        step(2);
        wr(SEL_DIV, 8'h00);
        rd(SEL_CNT, v); check("R4", "clear with tap high", v, 1);

        // R5: control writes and spurious steps.
        setup(1, 2, 0);
        wr(SEL_CTL, 8'h00);
        rd(SEL_CNT, v); check("R5", "disable while high", v, 1);
        setup(1, 2, 0);
        wr(SEL_CTL, 8'h06);
        rd(SEL_CNT, v); check("R5", "switch to low tap", v, 1);
        setup(1, 2, 0);
        wr(SEL_CTL, 8'hF5);
        rd(SEL_CNT, v); check("R5", "rewrite keeps high", v, 0);
        rd(SEL_CTL, v); check("R5", "ctl readback", v, 8'hFD);
        setup(2, 8, 0);
        wr(SEL_CTL, 8'h05);
        rd(SEL_CNT, v); check("R5", "bit3 high to bit1 low", v, 1);
        wr(SEL_CTL, 8'h00);
        wr(SEL_CNT, 8'h00);
        wr(SEL_DIV, 8'h00);
        step(127);
        wr(SEL_CTL, 8'h04);
        rd(SEL_CNT, v); check("R5", "enable while high", v, 0);
        wr(SEL_CTL, 8'h00);
        rd(SEL_CNT, v); check("R5", "disable bit7 high", v, 1);

        // R3: overflow reload and one-cycle request.
        wr(SEL_MOD, 8'h77);
        setup(1, 3, 8'hFF);
        base = irq_seen;
        step(1);
        rd(SEL_CNT, v); check("R3", "overflow reload", v, 8'h77);
        check("R3", "irq high", int'(irq_timer), 1);
        step(1);
        check("R3", "irq low next", int'(irq_timer), 0);
        check("R3", "one pulse", irq_seen - base, 1);

        // R6: CPU write beats a coincident step.
        setup(1, 3, 0);
        wr(SEL_CNT, 8'h40);
        rd(SEL_CNT, v); check("R6", "write wins", v, 8'h40);
        setup(1, 3, 8'hFF);
        base = irq_seen;
        wr(SEL_CNT, 8'h10);
        step(1);
        rd(SEL_CNT, v); check("R6", "write over overflow", v, 8'h10);
        check("R6", "no irq", irq_seen - base, 0);

        // R8: modulo write on the overflow edge affects only later reloads.
        wr(SEL_MOD, 8'h22);
        setup(1, 3, 8'hFF);
        wr(SEL_MOD, 8'h99);
        rd(SEL_CNT, v); check("R8", "old modulo used", v, 8'h22);
        rd(SEL_MOD, v); check("R8", "new modulo stored", v, 8'h99);

        // R7: reset in the middle of operation.
        setup(1, 40, 8'h33);
        rst_n = 1'b0;
        step(1);
        rd(SEL_DIV, v); check("R7", "div on reset", v, 0);
        rd(SEL_CNT, v); check("R7", "cnt on reset", v, 0);
        rd(SEL_MOD, v); check("R7", "mod on reset", v, 0);
        rd(SEL_CTL, v); check("R7", "ctl on reset", v, 8'hF8);
        rst_n = 1'b1;
        step(2);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule